// File: doc/BRIEF.md
# Serial Audio Bit Clock and Frame Generator

This block turns a fast reference clock into the timing of a two-channel serial audio link: a bit clock, a channel-select line, and one-cycle strobes that tell the neighbouring transmit and receive shifters when to change data and when to capture it. Data is launched at the falling bit-clock edge and captured at the rising edge. The channel-select line follows standard I2S framing. It moves one bit period before the most significant bit of each channel slot.

Software-visible timing comes in as one 32-bit control word. A low field sets the bit-clock half period in reference cycles, minus one. A field higher up sets the slot length in bits, minus one. The generator runs while either direction is enabled. Each run begins with a fresh frame on the left slot. A new control word is adopted only when a frame ends, so a frame in flight always completes with the timing it started with. All logic runs in the reference clock domain with a synchronous active-high reset.

Top module: `aud_bclk_framer`

## Requirements
- R1: While reset is held, and from the cycle after both `tx_en` and `rx_en` are low, `bclk`, `ws`, `drive_stb`, `sample_stb` and `frame_stb` are all 0.
- R2: The cycle after the enable OR rises from 0, the generator begins a new frame. `frame_stb` and `drive_stb` are 1, `bclk` is 0, `slot_chan` is 0 (left) and `slot_bit` is 0. Either enable alone starts it.
- R3: Each bit-clock phase lasts D+1 reference cycles, where D = `cfg_word[5:0]` (0 to 63). The first rising edge comes D+1 cycles after the start cycle, and the bit period is 2·(D+1) cycles.
- R4: `ws` is 0 for the left channel and 1 for the right channel. It changes only together with `drive_stb`, at the start of the last bit of each slot. At frame start it is 0, or 1 when slots are one bit long.
- R5: `sample_stb` is 1 for exactly the cycles in which `bclk` has just gone from 0 to 1. `drive_stb` is 1 only while `bclk` is 0. The two strobes are never 1 together.
- R6: With W = `cfg_word[21:16]`, a frame holds two slots of W+1 bits, so 2·(W+1) rising edges. It lasts 4·(W+1)·(D+1) cycles. `frame_stb` comes with the drive strobe of the left slot's first bit, where `slot_bit` is 0.
- R7: Bits 31:22 and 15:6 of `cfg_word` have no effect on the output timing.
- R8: A change of `cfg_word` during a frame does not alter that frame's length. The new D and W apply from the next `frame_stb` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_word | input | 32 | Clock control word: half-period divider in [5:0], slot size minus one in [21:16] |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, 0 = left, 1 = right |
| drive_stb | output | 1 | One-cycle pulse at each falling bit-clock edge and at frame start: launch the next bit |
| sample_stb | output | 1 | One-cycle pulse at each rising bit-clock edge: capture the current bit |
| frame_stb | output | 1 | One-cycle pulse at the first bit of the left slot |
| slot_chan | output | 1 | Channel whose bit is currently on the line |
| slot_bit | output | 6 | Index of the current bit inside its slot, 0 = MSB |

## Verification
A half-period counter that drifts by one shows up at the very next bit-clock edge: the gap between strobes moves off D+1. A wrong bit or slot index shows up within one slot, because `ws` moves on the wrong drive strobe. The same fault also makes the frame length and the number of rising edges between frame strobes come out wrong by the end of that frame. A control word latched at the wrong moment shows up only at the frame boundary after the write. The current frame comes out too short, or the next one keeps the old length. For that reason the bench measures two consecutive frames around a mid-frame change.

// File: rtl/aud_bclk_pkg.sv
package aud_bclk_pkg;

    // Field geometry of the clock control word
    localparam int CFG_W    = 32;
    localparam int DIV_W    = 6;
    localparam int WSZ_W    = 6;
    localparam int WSZ_LSB  = 16;
    localparam int WSZ_DEF  = 31;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic [WSZ_W-1:0] wsz;
        logic [DIV_W-1:0] div;
    } bclk_cfg_t;

    typedef struct packed {
        logic drive;
        logic sample;
        logic frame;
    } bclk_stb_t;

    function automatic bclk_cfg_t cfg_unpack(input logic [CFG_W-1:0] word);
        bclk_cfg_t c;
        c.div = word[DIV_W-1:0];
        c.wsz = word[WSZ_LSB +: WSZ_W];
        return c;
    endfunction

    // Channel select level for a bit: it announces the other channel on the last bit of a slot
    function automatic logic ws_level(input chan_e ch, input logic last_bit);
        return last_bit ? ~ch : ch;
    endfunction

endpackage

// File: rtl/aud_cfg_hold.sv
module aud_cfg_hold
    import aud_bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_word,
    output bclk_cfg_t        cfg_nxt,
    output bclk_cfg_t        cfg_act
);

    localparam bclk_cfg_t CFG_RST = '{wsz: WSZ_W'(WSZ_DEF), div: '0};

    logic unused_cfg_bits;

    assign cfg_nxt = cfg_unpack(cfg_word);
    assign unused_cfg_bits = ^{cfg_word[CFG_W-1:WSZ_LSB+WSZ_W], cfg_word[WSZ_LSB-1:DIV_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= CFG_RST;
        end else if (load) begin
            cfg_act <= cfg_nxt;
        end
    end

endmodule

// File: rtl/aud_half_timer.sv
module aud_half_timer
    import aud_bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             half_done
);

    logic [DIV_W-1:0] hcnt;
    logic             at_end;

    assign at_end    = (hcnt == div);
    assign half_done = !clear && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hcnt <= '0;
        end else if (at_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/aud_bit_seq.sv
module aud_bit_seq
    import aud_bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             half_done,
    input  bclk_cfg_t        cfg_nxt,
    input  bclk_cfg_t        cfg_act,
    output logic             running,
    output logic             load,
    output logic             bclk,
    output logic             ws,
    output chan_e            chan,
    output logic [WSZ_W-1:0] bitc,
    output bclk_stb_t        stb
);

    logic             start;
    logic             fall_now;
    logic             slot_end;
    logic             frame_end;
    logic [WSZ_W-1:0] nbit;
    chan_e            nchan;
    logic [WSZ_W-1:0] wsz_use;

    assign start     = run && !running;
    assign fall_now  = running && run && half_done && bclk;
    assign slot_end  = (bitc == cfg_act.wsz);
    assign frame_end = fall_now && slot_end && (chan == CH_RIGHT);
    assign load      = start || frame_end;

    assign nbit    = slot_end ? '0 : bitc + 1'b1;
    assign nchan   = slot_end ? chan_e'(~chan) : chan;
    assign wsz_use = frame_end ? cfg_nxt.wsz : cfg_act.wsz;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            running <= 1'b0;
            bclk    <= 1'b0;
            ws      <= 1'b0;
            chan    <= CH_LEFT;
            bitc    <= '0;
            stb     <= '0;
        end else if (!running) begin
            running <= 1'b1;
            bclk    <= 1'b0;
            chan    <= CH_LEFT;
            bitc    <= '0;
            ws      <= ws_level(CH_LEFT, cfg_nxt.wsz == '0);
            stb     <= '{drive: 1'b1, sample: 1'b0, frame: 1'b1};
        end else begin
            stb <= '0;
            if (half_done) begin
                if (!bclk) begin
                    bclk       <= 1'b1;
                    stb.sample <= 1'b1;
                end else begin
                    bclk      <= 1'b0;
                    stb.drive <= 1'b1;
                    stb.frame <= frame_end;
                    chan      <= nchan;
                    bitc      <= nbit;
                    ws        <= ws_level(nchan, nbit == wsz_use);
                end
            end
        end
    end

endmodule

// File: rtl/aud_bclk_framer.sv
module aud_bclk_framer
    import aud_bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             bclk,
    output logic             ws,
    output logic             drive_stb,
    output logic             sample_stb,
    output logic             frame_stb,
    output logic             slot_chan,
    output logic [WSZ_W-1:0] slot_bit
);

    logic      run;
    logic      running;
    logic      load;
    logic      half_done;
    bclk_cfg_t cfg_nxt;
    bclk_cfg_t cfg_act;
    chan_e     chan;
    bclk_stb_t stb;

    assign run = tx_en || rx_en;

    aud_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cfg_word (cfg_word),
        .cfg_nxt  (cfg_nxt),
        .cfg_act  (cfg_act)
    );

    aud_half_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (!running),
        .div       (cfg_act.div),
        .half_done (half_done)
    );

    aud_bit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half_done (half_done),
        .cfg_nxt   (cfg_nxt),
        .cfg_act   (cfg_act),
        .running   (running),
        .load      (load),
        .bclk      (bclk),
        .ws        (ws),
        .chan      (chan),
        .bitc      (slot_bit),
        .stb       (stb)
    );

    assign drive_stb  = stb.drive;
    assign sample_stb = stb.sample;
    assign frame_stb  = stb.frame;
    assign slot_chan  = chan;

endmodule

// File: rtl/aud_bclk_chk.sv
module aud_bclk_chk
    import aud_bclk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             rx_en,
    input logic             bclk,
    input logic             ws,
    input logic             drive_stb,
    input logic             sample_stb,
    input logic             frame_stb,
    input logic             slot_chan,
    input logic [WSZ_W-1:0] slot_bit,
    input logic [DIV_W-1:0] act_div
);

    logic       run;
    logic       gap_ok;
    logic [7:0] gap;

    assign run = tx_en || rx_en;

    // Cycles since the last bit-clock strobe, valid once a run has produced one
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            gap_ok <= 1'b0;
            gap    <= 8'd0;
        end else if (drive_stb || sample_stb) begin
            gap_ok <= 1'b1;
            gap    <= 8'd1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 8'd1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!bclk && !ws && !drive_stb && !sample_stb && !frame_stb));

    p_start_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |=> (frame_stb && drive_stb && !bclk && !slot_chan && slot_bit == '0));

    p_half_period_r3: assert property (@(posedge clk) disable iff (rst)
        (gap_ok && (drive_stb || sample_stb)) |-> (gap == 8'($past(act_div)) + 8'd1));

    p_ws_on_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(run) && $past(run, 2) && (ws != $past(ws)))
            |-> drive_stb);

    p_sample_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        sample_stb == (bclk && !$past(bclk)));

    p_drive_low_r5: assert property (@(posedge clk) disable iff (rst)
        drive_stb |-> (!bclk && !sample_stb));

    p_frame_head_r6: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> (drive_stb && !slot_chan && slot_bit == '0));

endmodule

bind aud_bclk_framer aud_bclk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .bclk       (bclk),
    .ws         (ws),
    .drive_stb  (drive_stb),
    .sample_stb (sample_stb),
    .frame_stb  (frame_stb),
    .slot_chan  (slot_chan),
    .slot_bit   (slot_bit),
    .act_div    (cfg_act.div)
);

// File: tb/test_aud_bclk_framer.sv
module test_aud_bclk_framer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic [31:0] word;
        logic [7:0]  div;
        logic [7:0]  wsz;
    } vec_t;

    // Control word next to the divider and slot size it is meant to encode
    localparam vec_t VECS [NVEC] = '{
        '{32'h001F_0000, 8'd0,  8'd31},
        '{32'h000F_0002, 8'd2,  8'd15},
        '{32'h0003_003F, 8'd63, 8'd3},
        '{32'h0000_0001, 8'd1,  8'd0},
        '{32'hFFC7_FFC4, 8'd4,  8'd7},
        '{32'h0001_0000, 8'd0,  8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] cfg_word = 32'h001F_0000;
    logic        bclk, ws, drive_stb, sample_stb, frame_stb, slot_chan;
    logic [5:0]  slot_bit;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_bclk_framer i_aud_bclk_framer (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .cfg_word   (cfg_word),
        .bclk       (bclk),
        .ws         (ws),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .frame_stb  (frame_stb),
        .slot_chan  (slot_chan),
        .slot_bit   (slot_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int quiet();
        return int'(bclk || ws || drive_stb || sample_stb || frame_stb);
    endfunction

    // Run one frame after enabling; k counts negedges after the start edge
    task automatic run_frame(input vec_t v, input string tag);
        int p, w, rise_k, ws_k, n_rise, frame_k;
        logic ws0;
        p = 2 * (int'(v.div) + 1);
        w = int'(v.wsz);
        rise_k = -1; ws_k = -1; n_rise = 0; frame_k = -1;
        cfg_word = v.word;
        tx_en = 1'b1;
        @(negedge clk);
        chk(frame_stb && drive_stb && !bclk && !slot_chan && slot_bit == 0,
            {tag, " R2 frame head"}, int'(frame_stb), 1);
        chk(ws == (w == 0), {tag, " R4 ws at start"}, int'(ws), int'(w == 0));
        ws0 = ws;
        for (int k = 1; k < 20000; k++) begin
            @(negedge clk);
            if (sample_stb) begin
                n_rise++;
                if (rise_k < 0) rise_k = k;
            end
            if (ws != ws0 && ws_k < 0) ws_k = k;
            if (frame_stb) begin
                frame_k = k;
                break;
            end
        end
        chk(rise_k == p / 2, {tag, " R3 first rise"}, rise_k, p / 2);
        chk(ws_k == ((w == 0) ? 1 : w) * p, {tag, " R4 ws toggle"}, ws_k, ((w == 0) ? 1 : w) * p);
        chk(n_rise == 2 * (w + 1), {tag, " R5 rises per frame"}, n_rise, 2 * (w + 1));
        chk(frame_k == 2 * (w + 1) * p, {tag, " R6 frame length"}, frame_k, 2 * (w + 1) * p);
        tx_en = 1'b0;
        @(negedge clk);
        chk(quiet() == 0, {tag, " R1 idle after stop"}, quiet(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k, f1, f2, r1;
        repeat (4) @(negedge clk);
        chk(quiet() == 0, "R1 during reset", quiet(), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(quiet() == 0, "R1 after reset", quiet(), 0);

        // Vector table: R3, R4, R5, R6, and R7 via the vector with junk bits
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i], $sformatf("vec%0d", i));
            repeat (3) @(negedge clk);
        end

        // R2: receive enable alone starts a frame; R1: stop mid-frame
        cfg_word = 32'h0003_0001;
        rx_en = 1'b1;
        @(negedge clk);
        chk(frame_stb && drive_stb && !bclk, "R2 rx-only start", int'(frame_stb), 1);
        repeat (4) @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk(quiet() == 0, "R1 stop mid-frame", quiet(), 0);
        k = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            k += quiet();
        end
        chk(k == 0, "R1 stays idle", k, 0);

        // R8: change control word mid-frame (D=1,W=3 -> D=0,W=1)
        cfg_word = 32'h0003_0001;
        tx_en = 1'b1;
        @(negedge clk);
        f1 = -1; f2 = -1; r1 = -1;
        for (int j = 1; j < 200; j++) begin
            @(negedge clk);
            if (j == 5) cfg_word = 32'h0001_0000;
            if (f1 >= 0 && sample_stb && r1 < 0) r1 = j;
            if (frame_stb) begin
                if (f1 < 0) f1 = j;
                else begin
                    f2 = j;
                    break;
                end
            end
        end
        chk(f1 == 32, "R8 running frame keeps length", f1, 32);
        chk(f2 == 40, "R8 next frame uses new word", f2, 40);
        chk(r1 == 33, "R8 new divider after boundary", r1, 33);
        tx_en = 1'b0;
        @(negedge clk);
        chk(quiet() == 0, "R1 idle after R8 run", quiet(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule